// File: doc/BRIEF.md
# Strobe-Synchronized Fetch Cycle Generator

This block turns a once-per-bit fetch request into exactly one memory-access cycle that is aligned to a periodic row strobe from the memory controller. A rising edge of the baud tick arms a request. The next rising edge of the strobe opens the access cycle, and the strobe rising edge after that closes it. Starting the cycle consumes the request. A second access therefore needs a fresh baud edge, which limits the block to one access per baud period.

The baud tick and the strobe arrive from outside the system clock domain. Each passes through a synchronizer of `SYNC_STAGES` flops and then an edge detector. The baud event then goes through a further delay of `ARM_DELAY` clock cycles, so the request is sampled a little after the bit boundary. The inhibit input is synchronous to `clk`. It blocks arming, and it cancels a request that is armed but has not started. Address generation and the pixel data path sit outside this block.

Top module: `fetch_cycle_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first armed strobe edge, `access` is 0, `access_n` is 1 and no request is armed.
- R2: `access_n` is the logical complement of `access` in every cycle.
- R3: After a baud rising edge arms a request with `inhibit` low, the next strobe rising edge sets `access` to 1. The change appears on the (SYNC_STAGES+1)-th rising clock edge at which `strobe` is sampled high. The arming edge is the (SYNC_STAGES+ARM_DELAY+1)-th rising clock edge at which `baud_tick` is sampled high.
- R4: While `access` is 1, it stays 1 until the next strobe rising edge, which returns it to 0 with the same latency as R3.
- R5: Starting an access clears the request. Further strobe rising edges cause no second access until a new baud rising edge arms another request.
- R6: A baud arming event that occurs while `inhibit` is high arms nothing.
- R7: If `inhibit` is high on a clock edge while a request is armed and no access is active, the request is cancelled and no access follows from it.
- R8: A baud arming event while a request is already armed leaves a single request, and it yields only one access.
- R9: A baud arming event while `access` is 1 is ignored. After that access ends, no further access occurs without a new baud edge.
- R10: If a baud arming event and a strobe rising event reach the controller on the same clock edge while nothing is armed, the request is armed but not started. The access begins only on the following strobe rising edge.
- R11: Both inputs act on rising edges only. Holding `baud_tick` high arms once. Holding `strobe` high neither starts nor ends more than one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Baud-rate tick, asynchronous; a rising edge arms a request |
| strobe | input | 1 | Memory row strobe, asynchronous; rising edges start and end the access |
| inhibit | input | 1 | Synchronous to `clk`; blocks arming and cancels a pending request |
| access | output | 1 | High during the memory-access cycle |
| access_n | output | 1 | Complement of `access`, from its own register |

## Verification
The bound checker tests the following on every clock:
- the complement relation between the two outputs;
- that an armed strobe event opens the cycle and an active strobe event closes it;
- that the cycle holds between strobe events;
- that no request remains armed while a cycle runs;
- that inhibit blocks or cancels requests.

The end-to-end latencies through the synchronizers and the arming delay can only be shown by the bench's scenarios. The same applies to the effects of held-high inputs, duplicate baud edges and coincident events. The bench reaches these through a cycle-exact model fed only with port values, and it also counts the access cycles each scenario produces.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef struct packed {
    logic armed;
    logic active;
  } fetch_st_t;

  localparam fetch_st_t FETCH_IDLE = '{armed: 1'b0, active: 1'b0};

  // Next-state rule of the fetch controller.
  // Active cycle: only a strobe event matters, and it closes the cycle.
  // Idle and armed: inhibit cancels, otherwise a strobe event opens the cycle.
  // Idle and unarmed: a baud event arms unless inhibited.
  function automatic fetch_st_t fetch_next(input fetch_st_t cur,
                                           input logic      strobe_evt,
                                           input logic      arm_evt,
                                           input logic      inhibit);
    fetch_st_t nxt;
    nxt = cur;
    if (cur.active) begin
      nxt.armed = 1'b0;
      if (strobe_evt) nxt.active = 1'b0;
    end else if (cur.armed) begin
      if (inhibit) begin
        nxt.armed = 1'b0;
      end else if (strobe_evt) begin
        nxt.armed  = 1'b0;
        nxt.active = 1'b1;
      end
    end else if (arm_evt && !inhibit) begin
      nxt.armed = 1'b1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/fcg_edge_sync.sv
// Multi-flop synchronizer followed by a rising-edge detector.
// STAGES must be at least 2.
module fcg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/fcg_pulse_delay.sv
// Fixed delay of a one-cycle pulse by DEPTH clock cycles (DEPTH may be 0).
module fcg_pulse_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_line
      logic [DEPTH-1:0] line;
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      line[i] <= 1'b0;
          else if (i == 0) line[i] <= din;
          else             line[i] <= line[(i == 0) ? 0 : i-1];
        end
      end
      assign dout = line[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fcg_ctrl.sv
// Arm / start / end controller with self-clearing request.
module fcg_ctrl
  import fetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_evt,
  input  logic arm_evt,
  input  logic inhibit,
  output logic armed,
  output logic access,
  output logic access_n
);

  fetch_st_t st_q, st_d;
  logic      acc_n_q;

  always_comb st_d = fetch_next(st_q, strobe_evt, arm_evt, inhibit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FETCH_IDLE;
      acc_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      acc_n_q <= ~st_d.active;
    end
  end

  assign armed    = st_q.armed;
  assign access   = st_q.active;
  assign access_n = acc_n_q;

endmodule

// File: rtl/fetch_cycle_gen.sv
module fetch_cycle_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int ARM_DELAY   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic strobe,
  input  logic inhibit,
  output logic access,
  output logic access_n
);

  logic baud_rise;
  logic strobe_evt;
  logic arm_evt;
  logic armed;

  fcg_edge_sync #(.STAGES(SYNC_STAGES)) u_baud_sync (
    .clk (clk), .rst_n (rst_n), .din (baud_tick), .rise (baud_rise)
  );

  fcg_edge_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk (clk), .rst_n (rst_n), .din (strobe), .rise (strobe_evt)
  );

  fcg_pulse_delay #(.DEPTH(ARM_DELAY)) u_arm_delay (
    .clk (clk), .rst_n (rst_n), .din (baud_rise), .dout (arm_evt)
  );

  fcg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_evt (strobe_evt),
    .arm_evt    (arm_evt),
    .inhibit    (inhibit),
    .armed      (armed),
    .access     (access),
    .access_n   (access_n)
  );

endmodule

// File: rtl/fetch_cycle_gen_chk.sv
module fetch_cycle_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic access,
  input logic access_n,
  input logic armed,
  input logic strobe_evt,
  input logic arm_evt,
  input logic inhibit
);

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    access_n == !access) else $error("complement broken"); // R2

  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && armed && strobe_evt && !inhibit) |=> access) else $error("no start"); // R3

  AST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (access && strobe_evt) |=> !access) else $error("no end"); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !strobe_evt) |=> access) else $error("cycle dropped"); // R4

  AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access) |-> $past(armed && strobe_evt)) else $error("start without request"); // R5

  AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> !armed) else $error("request kept during cycle"); // R9

  AST_NO_ARM_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !access && arm_evt && inhibit) |=> !armed) else $error("armed under inhibit"); // R6

  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !access && inhibit) |=> (!armed && !access)) else $error("inhibit ignored"); // R7

endmodule

bind fetch_cycle_gen fetch_cycle_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .access     (access),
  .access_n   (access_n),
  .armed      (armed),
  .strobe_evt (strobe_evt),
  .arm_evt    (arm_evt),
  .inhibit    (inhibit)
);

// File: tb/fetch_cycle_gen_test.sv
`timescale 1ns/1ps
module fetch_cycle_gen_test;

  localparam int SY = 2;
  localparam int DL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic strobe = 1'b0;
  logic inhibit = 1'b0;
  logic access, access_n;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int cycles = 0;
  string cur_req = "R1";
  logic prev_access = 1'b0;

  always #4 clk = ~clk;

  fetch_cycle_gen #(.SYNC_STAGES(SY), .ARM_DELAY(DL)) uut (
    .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick), .strobe (strobe),
    .inhibit (inhibit), .access (access), .access_n (access_n)
  );

  // Reference model: sample history queues, newest at index 0.
  bit sq[$];
  bit bq[$];
  bit m_armed, m_active;

  always @(posedge clk) begin
    if (!rst_n) begin
      sq = {}; bq = {};
      for (int i = 0; i < 12; i++) begin sq.push_back(1'b0); bq.push_back(1'b0); end
      m_armed = 1'b0; m_active = 1'b0;
    end else begin
      bit ev_s, ev_b;
      ev_s = sq[SY-1] && !sq[SY];
      ev_b = bq[SY+DL-1] && !bq[SY+DL];
      if (m_active) begin
        if (ev_s) m_active = 1'b0;
      end else if (m_armed) begin
        if (inhibit) m_armed = 1'b0;
        else if (ev_s) begin m_armed = 1'b0; m_active = 1'b1; end
      end else if (ev_b && !inhibit) begin
        m_armed = 1'b1;
      end
      sq.push_front(strobe); void'(sq.pop_back());
      bq.push_front(baud_tick); void'(bq.pop_back());
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (access !== m_active) begin
        errors++;
        $display("FAIL %s: access=%b expected %b at cycle %0d", cur_req, access, m_active, cycles);
      end
      checks++;
      if (access_n !== ~access) begin
        errors++;
        $display("FAIL R2: access_n=%b expected %b", access_n, ~access);
      end
      if (access === 1'b1 && prev_access === 1'b0) starts++;
      prev_access = access;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic baud_pulse();
    @(negedge clk) baud_tick = 1'b1;
    idle(3);
    baud_tick = 1'b0;
  endtask

  task automatic strobe_pulse();
    @(negedge clk) strobe = 1'b1;
    idle(3);
    strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    idle(2);
    chk(access === 1'b0, "R1", access, 0);
    chk(access_n === 1'b1, "R1", access_n, 1);
    rst_n = 1'b1;
    idle(4);
    chk(access === 1'b0 && starts == 0, "R1", access, 0);

    // R3 / R4 / R5: basic arm, start, end, self-clear
    cur_req = "R3";
    baud_pulse(); idle(8);
    chk(access === 1'b0, "R3", access, 0);
    strobe_pulse(); idle(6);
    chk(access === 1'b1, "R3", access, 1);
    cur_req = "R4";
    idle(10);
    chk(access === 1'b1, "R4", access, 1);
    strobe_pulse(); idle(6);
    chk(access === 1'b0, "R4", access, 0);
    cur_req = "R5";
    strobe_pulse(); idle(6); strobe_pulse(); idle(6);
    chk(starts == 1, "R5", starts, 1);

    // R6: arming blocked by inhibit
    cur_req = "R6";
    inhibit = 1'b1; baud_pulse(); idle(8); inhibit = 1'b0;
    strobe_pulse(); idle(8);
    chk(starts == 1 && access === 1'b0, "R6", starts, 1);

    // R7: inhibit cancels a pending request
    cur_req = "R7";
    baud_pulse(); idle(8);
    @(negedge clk) inhibit = 1'b1;
    @(negedge clk) inhibit = 1'b0;
    strobe_pulse(); idle(8);
    chk(starts == 1 && access === 1'b0, "R7", starts, 1);

    // R8: repeated baud edges make one request
    cur_req = "R8";
    baud_pulse(); idle(8); baud_pulse(); idle(8);
    strobe_pulse(); idle(8);
    chk(access === 1'b1, "R8", access, 1);
    strobe_pulse(); idle(8); strobe_pulse(); idle(8);
    chk(starts == 2 && access === 1'b0, "R8", starts, 2);

    // R9: baud edge during an active cycle is ignored
    cur_req = "R9";
    baud_pulse(); idle(8); strobe_pulse(); idle(8);
    baud_pulse(); idle(8);
    chk(access === 1'b1, "R9", access, 1);
    strobe_pulse(); idle(8); strobe_pulse(); idle(8);
    chk(starts == 3 && access === 1'b0, "R9", starts, 3);

    // R10: arm and strobe events on the same controller edge
    cur_req = "R10";
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk);
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    idle(2); strobe = 1'b0;
    idle(8);
    chk(access === 1'b0, "R10", access, 0);
    strobe_pulse(); idle(8);
    chk(access === 1'b1 && starts == 4, "R10", starts, 4);
    strobe_pulse(); idle(8);

    // R11: levels held high act only once
    cur_req = "R11";
    @(negedge clk) baud_tick = 1'b1;
    idle(10);
    @(negedge clk) strobe = 1'b1;
    idle(25);
    chk(access === 1'b1, "R11", access, 1);
    strobe = 1'b0; idle(5);
    strobe_pulse(); idle(8);
    chk(access === 1'b0, "R11", access, 0);
    strobe_pulse(); idle(8);
    chk(starts == 5 && access === 1'b0, "R11", starts, 5);
    baud_tick = 1'b0; idle(5);

    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    checks++; errors++;
    $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
    finish_run();
  end

endmodule